// File: doc/BRIEF.md
# Virtualized Pipeline Stage Scheduler

This block runs a logical pipeline of `NV` virtual stages on a ring of `NP` physical stripes, with `NV` greater than `NP`. It rewrites one stripe each clock cycle. The stripes are taken in round-robin order, and each new occupant is the next virtual stage in sequence. The other stripes keep computing while that stripe is loaded. Each rewrite works in three parts. The stripe receives a complete configuration word from a wide configuration vector in a single cycle. The register state of the virtual stage being evicted is written to a per-stage state memory. The saved state of the incoming stage is loaded into the stripe.

Data moves only from a stripe to its ring successor. A virtual stage always runs in the stripe that follows the one holding its predecessor stage, one cycle later. A datum therefore follows the configuration wave through all `NV` stages, and the whole logical pipeline is never resident at one time. Input is accepted only while the stripe holding stage 0 is computing. Results leave the stripe holding the last stage together with a valid flag.

Each stage applies one of four operations to an `W`-bit datum using an `W`-bit constant. Two of the operations are stateless and two use per-stage state, so a stage's history survives eviction.

Top module: `vps_pipe`

## Requirements
- R1: After reset, `out_valid_o`, `out_data_o` and `in_ready_o` are 0. No stripe is configured and no input is accepted until `start_i` is pulsed.
- R2: Once started, exactly one stripe is reconfigured per cycle. The stripe index advances by one modulo `NP` and the virtual stage index advances by one modulo `NV`. Counting the first cycle after the start edge as cycle 0, stage 0 is loaded in cycles where cycle mod `NV` is 0.
- R3: `in_ready_o` is high in exactly `NP-1` of every `NV` cycles: cycles 1 and 2 mod 5 for the defaults. `in_valid_i` is ignored while `in_ready_o` is low.
- R4: For the stateless operations, each result equals the accepted datum passed through stages 0 to `NV-1` in order. Each configuration entry `v` sits at `cfg_i[v*(W+2) +: W+2]`, with the op code in the top 2 bits and constant `k` below it. Op 0 gives `y=x+k` and op 1 gives `y=x^k`, both modulo 2^W.
- R5: A datum accepted in cycle c appears on `out_data_o` with `out_valid_o` high in cycle c+`NV`.
- R6: Stateful stages behave as in a non-virtualized pipeline across evictions. Op 2 gives `s=s+x` and `y=s`. Op 3 gives `y=s` and `s=x`. State changes only on a valid datum.
- R7: After reset, the saved state of every virtual stage is zero. The first datum through an op-3 stage yields 0 from that stage.
- R8: Exactly one valid result is produced per accepted datum, in acceptance order. Idle input cycles produce no result.
- R9: A stripe produces no new output in the cycle it is being reconfigured. `out_valid_o` is high only in cycles that follow a cycle in which input was accepted, `NV` cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts the reconfiguration rotation |
| cfg_i | input | NV*(W+2) | Configuration store contents, one word per virtual stage |
| in_data_i | input | W | Stream input datum |
| in_valid_i | input | 1 | Input datum present |
| in_ready_o | output | 1 | Stage 0 is computing; input is taken this cycle |
| out_data_o | output | W | Result of the last virtual stage |
| out_valid_o | output | 1 | Result valid |

## Verification
The hardest case is the return of a stateful stage after eviction. This is only visible when several data pass through an accumulating or delaying stage across many rotations of the ring. The stateful tests place op 2 and op 3 stages at different virtual positions and stream 40 data through them. The results are compared with a five-stage model that has no virtualization, so any lost or misrouted save or restore changes a later result. A bubble pattern offers data only in some ready cycles, which checks that state and output move only on valid data.

// File: rtl/vps_pkg.sv
package vps_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_XOR = 2'd1,
    OP_ACC = 2'd2,
    OP_DLY = 2'd3
  } op_e;
endpackage

// File: rtl/vps_sched.sv
module vps_sched #(
  parameter int NP = 3,
  parameter int NV = 5,
  localparam int SW = (NP > 1) ? $clog2(NP) : 1,
  localparam int VW = (NV > 1) ? $clog2(NV) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          run_o,
  output logic [SW-1:0] sidx_o,
  output logic [VW-1:0] vidx_o
);
  logic          run_q;
  logic [SW-1:0] sidx_q;
  logic [VW-1:0] vidx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      sidx_q <= '0;
      vidx_q <= '0;
    end else if (!run_q) begin
      if (start_i) run_q <= 1'b1;
    end else begin
      sidx_q <= (int'(sidx_q) == NP-1) ? '0 : sidx_q + 1'b1;
      vidx_q <= (int'(vidx_q) == NV-1) ? '0 : vidx_q + 1'b1;
    end
  end

  assign run_o  = run_q;
  assign sidx_o = sidx_q;
  assign vidx_o = vidx_q;

  assert_stripe_rr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> (int'(sidx_q) == ((int'($past(sidx_q)) + 1) % NP)));
  assert_vstage_rr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> (int'(vidx_q) == ((int'($past(vidx_q)) + 1) % NV)));
  assert_stays_running_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q);
endmodule

// File: rtl/vps_state_mem.sv
module vps_state_mem #(
  parameter int NV = 5,
  parameter int W  = 8,
  localparam int VW = (NV > 1) ? $clog2(NV) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [VW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [VW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [NV];

  for (genvar v = 0; v < NV; v++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[v] <= '0;
      else if (we_i && int'(waddr_i) == v)      mem_q[v] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // restore never reads the entry being saved in the same cycle
  assert_no_rw_clash_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (waddr_i != raddr_i));
endmodule

// File: rtl/vps_stripe.sv
module vps_stripe
  import vps_pkg::*;
#(
  parameter int W  = 8,
  parameter int VW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_en_i,
  input  op_e           cfg_op_i,
  input  logic [W-1:0]  cfg_k_i,
  input  logic [VW-1:0] cfg_vs_i,
  input  logic [W-1:0]  restore_i,
  input  logic [W-1:0]  in_dat_i,
  input  logic          in_val_i,
  output logic          res_o,
  output logic          act_o,
  output logic [VW-1:0] vs_o,
  output logic [W-1:0]  st_o,
  output logic [W-1:0]  y_o,
  output logic [W-1:0]  dat_o,
  output logic          val_o
);
  logic          res_q, val_q;
  op_e           op_q;
  logic [W-1:0]  k_q, st_q, dat_q, y, st_n;
  logic [VW-1:0] vs_q;
  logic          act;

  assign act = res_q && !cfg_en_i;

  always_comb begin
    y    = in_dat_i;
    st_n = st_q;
    unique case (op_q)
      OP_ADD: y = in_dat_i + k_q;
      OP_XOR: y = in_dat_i ^ k_q;
      OP_ACC: begin st_n = st_q + in_dat_i; y = st_n; end
      OP_DLY: begin y = st_q; st_n = in_dat_i; end
      default: y = in_dat_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= 1'b0;
      val_q <= 1'b0;
      op_q  <= OP_ADD;
      k_q   <= '0;
      st_q  <= '0;
      dat_q <= '0;
      vs_q  <= '0;
    end else if (cfg_en_i) begin
      res_q <= 1'b1;
      op_q  <= cfg_op_i;
      k_q   <= cfg_k_i;
      vs_q  <= cfg_vs_i;
      st_q  <= restore_i;
    end else if (res_q) begin
      val_q <= in_val_i;
      if (in_val_i) begin
        dat_q <= y;
        st_q  <= st_n;
      end
    end
  end

  assign res_o = res_q;
  assign act_o = act;
  assign vs_o  = vs_q;
  assign st_o  = st_q;
  assign y_o   = y;
  assign dat_o = dat_q;
  assign val_o = val_q;

  assert_cfg_holds_output_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> ($stable(dat_q) && $stable(val_q)));
  assert_state_on_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_q && !cfg_en_i && !in_val_i) |=> $stable(st_q));
endmodule

// File: rtl/vps_pipe.sv
module vps_pipe
  import vps_pkg::*;
#(
  parameter int W  = 8,
  parameter int NP = 3,
  parameter int NV = 5,
  localparam int CW = W + 2,
  localparam int SW = (NP > 1) ? $clog2(NP) : 1,
  localparam int VW = (NV > 1) ? $clog2(NV) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [NV*CW-1:0] cfg_i,
  input  logic [W-1:0]   in_data_i,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  output logic [W-1:0]   out_data_o,
  output logic           out_valid_o
);
  logic          run;
  logic [SW-1:0] sidx;
  logic [VW-1:0] vidx;
  logic [CW-1:0] cfg_word;
  logic [W-1:0]  restore;

  logic [NP-1:0] cfg_en, res, act, val, head_act, tail_hit, in_val;
  logic [VW-1:0] vs  [NP];
  logic [W-1:0]  st  [NP];
  logic [W-1:0]  y   [NP];
  logic [W-1:0]  dat [NP];
  logic [W-1:0]  in_dat [NP];

  vps_sched #(.NP(NP), .NV(NV)) u_sched (
    .clk_i, .rst_ni, .start_i,
    .run_o(run), .sidx_o(sidx), .vidx_o(vidx)
  );

  // full stripe configuration fetched in one cycle
  assign cfg_word = cfg_i[int'(vidx)*CW +: CW];

  vps_state_mem #(.NV(NV), .W(W)) u_mem (
    .clk_i, .rst_ni,
    .we_i    (run && res[sidx]),
    .waddr_i (vs[sidx]),
    .wdata_i (st[sidx]),
    .raddr_i (vidx),
    .rdata_o (restore)
  );

  for (genvar k = 0; k < NP; k++) begin : g_stripe
    localparam int PRED = (k + NP - 1) % NP;
    logic is_head;

    assign cfg_en[k]   = run && (int'(sidx) == k);
    assign is_head     = (vs[k] == '0);
    assign in_dat[k]   = is_head ? in_data_i  : dat[PRED];
    assign in_val[k]   = is_head ? in_valid_i : val[PRED];
    assign head_act[k] = act[k] && is_head;
    assign tail_hit[k] = act[k] && (int'(vs[k]) == NV-1);

    vps_stripe #(.W(W), .VW(VW)) u_stripe (
      .clk_i, .rst_ni,
      .cfg_en_i  (cfg_en[k]),
      .cfg_op_i  (op_e'(cfg_word[CW-1 -: 2])),
      .cfg_k_i   (cfg_word[W-1:0]),
      .cfg_vs_i  (vidx),
      .restore_i (restore),
      .in_dat_i  (in_dat[k]),
      .in_val_i  (in_val[k]),
      .res_o     (res[k]),
      .act_o     (act[k]),
      .vs_o      (vs[k]),
      .st_o      (st[k]),
      .y_o       (y[k]),
      .dat_o     (dat[k]),
      .val_o     (val[k])
    );
  end

  assign in_ready_o = |head_act;

  logic [W-1:0] tail_y;
  logic         tail_v;
  always_comb begin
    tail_y = '0;
    tail_v = 1'b0;
    for (int k = 0; k < NP; k++) begin
      if (tail_hit[k]) begin
        tail_y = y[k];
        tail_v = in_val[k];
      end
    end
  end

  logic [W-1:0] out_q;
  logic         out_v_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      out_v_q <= 1'b0;
    end else begin
      out_v_q <= tail_v;
      if (tail_v) out_q <= tail_y;
    end
  end

  assign out_data_o  = out_q;
  assign out_valid_o = out_v_q;

  assert_one_cfg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cfg_en) == (run ? 1 : 0));
  assert_single_head_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(head_act));
  assert_single_tail_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tail_hit));
  assert_out_from_tail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_v_q) |-> $past(|tail_hit));
  assert_idle_before_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!in_ready_o && res == '0));
endmodule

// File: tb/sim_vps_pipe.sv
`timescale 1ns/1ps
module sim_vps_pipe;
  localparam int W = 8, NP = 3, NV = 5, CW = W + 2, N = 40, MAXC = 400;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, in_valid_i = 1'b0;
  logic [NV*CW-1:0] cfg_i = '0;
  logic [W-1:0] in_data_i = '0, out_data_o;
  logic in_ready_o, out_valid_o;

  always #2.5 clk = ~clk;

  vps_pipe #(.W(W), .NP(NP), .NV(NV)) u0 (
    .clk_i(clk), .rst_ni, .start_i, .cfg_i, .in_data_i, .in_valid_i,
    .in_ready_o, .out_data_o, .out_valid_o
  );

  int n_chk = 0, n_fail = 0;
  logic [1:0]   op_t [NV];
  logic [W-1:0] k_t  [NV];
  logic [W-1:0] acc_d [N];
  int           acc_c [N];
  logic [W-1:0] out_d [MAXC];
  int           out_c [MAXC];
  logic [W-1:0] exp_d [N];
  int n_in, n_out;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; start_i = 1'b0; in_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_cfg();
    for (int v = 0; v < NV; v++) cfg_i[v*CW +: CW] = {op_t[v], k_t[v]};
  endtask

  task automatic ref_model();
    logic [W-1:0] s [NV];
    logic [W-1:0] x;
    for (int v = 0; v < NV; v++) s[v] = '0;
    for (int i = 0; i < N; i++) begin
      x = acc_d[i];
      for (int v = 0; v < NV; v++) begin
        case (op_t[v])
          2'd0: x = x + k_t[v];
          2'd1: x = x ^ k_t[v];
          2'd2: begin s[v] = s[v] + x; x = s[v]; end
          default: begin logic [W-1:0] t; t = s[v]; s[v] = x; x = t; end
        endcase
      end
      exp_d[i] = x;
    end
  endtask

  // streams N data; bubble>0 offers data only when cyc % bubble == 0
  task automatic run_stream(int bubble, string req);
    do_reset();
    load_cfg();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n_in = 0; n_out = 0;
    for (int cyc = 0; cyc < MAXC; cyc++) begin
      if (out_valid_o && n_out < MAXC) begin
        out_d[n_out] = out_data_o; out_c[n_out] = cyc; n_out++;
      end
      in_valid_i = (n_in < N) && (bubble == 0 || cyc % bubble == 0);
      in_data_i  = W'(n_in * 37 + 11);
      if (in_valid_i && in_ready_o) begin
        acc_d[n_in] = in_data_i; acc_c[n_in] = cyc; n_in++;
      end
      @(negedge clk);
    end
    in_valid_i = 1'b0;
    ref_model();
    chk(n_in == N, "R3 all data accepted", n_in, N);
    chk(n_out == n_in, "R8 one result per datum", n_out, n_in);
    for (int i = 0; i < N && i < n_out; i++) begin
      chk(out_d[i] == exp_d[i], req, int'(out_d[i]), int'(exp_d[i]));
      chk(out_c[i] == acc_c[i] + NV, "R5 R9 latency", out_c[i], acc_c[i] + NV);
    end
  endtask

  task automatic test_reset();
    do_reset();
    chk(out_valid_o == 1'b0, "R1 out_valid", int'(out_valid_o), 0);
    chk(out_data_o == '0, "R1 out_data", int'(out_data_o), 0);
    in_valid_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      chk(in_ready_o == 1'b0, "R1 ready before start", int'(in_ready_o), 0);
      @(negedge clk);
    end
    chk(out_valid_o == 1'b0, "R1 no output before start", int'(out_valid_o), 0);
    in_valid_i = 1'b0;
  endtask

  task automatic test_schedule();
    int cnt;
    do_reset();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 0;
    for (int cyc = 0; cyc < 25; cyc++) begin
      logic e;
      e = (cyc % NV == 1) || (cyc % NV == 2);
      chk(in_ready_o == e, "R2 ready phase", int'(in_ready_o), int'(e));
      cnt += int'(in_ready_o);
      @(negedge clk);
    end
    chk(cnt == 10, "R3 ready count", cnt, 10);
  endtask

  task automatic test_stateless();
    op_t = '{2'd0, 2'd1, 2'd0, 2'd1, 2'd0};
    k_t  = '{8'd3, 8'h5a, 8'd200, 8'h0f, 8'd17};
    run_stream(0, "R4 stateless result");
  endtask

  task automatic test_stateful();
    op_t = '{2'd2, 2'd0, 2'd3, 2'd1, 2'd2};
    k_t  = '{8'd0, 8'd9, 8'd0, 8'h33, 8'd0};
    run_stream(0, "R6 stateful result");
  endtask

  task automatic test_zero_init();
    op_t = '{2'd3, 2'd0, 2'd0, 2'd0, 2'd0};
    k_t  = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4};
    run_stream(0, "R7 result");
    chk(out_d[0] == 8'd10, "R7 first output from zero state", int'(out_d[0]), 10);
    chk(out_d[1] == 8'(acc_d[0] + 8'd10), "R7 second output", int'(out_d[1]),
        int'(8'(acc_d[0] + 8'd10)));
  endtask

  task automatic test_bubbles();
    op_t = '{2'd2, 2'd3, 2'd0, 2'd2, 2'd1};
    k_t  = '{8'd0, 8'd0, 8'd77, 8'd0, 8'hc3};
    run_stream(3, "R8 bubble result");
  endtask

  bit done = 1'b0;
  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_schedule();
    test_stateless();
    test_stateful();
    test_zero_init();
    test_bubbles();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule